// File: doc/BRIEF.md
# Three-Instruction Boundary Scan Test Port

This block is a serial test port for board-level testing. A four-wire serial link (test clock, mode select, data in, data out) walks the standard sixteen-state test controller. The controller loads a 3-bit instruction register, and the instruction selects which data register sits between the data input and output. Only three instructions are decoded. BYPASS puts a single flip-flop in the path so that devices chained data-out to data-in cost one bit each. SAMPLE/PRELOAD snapshots the pad inputs and loads the boundary hold stage without disturbing normal operation. EXTEST hands the pad outputs to the boundary hold stage.

Each pad owns one boundary cell with a shift flop and a hold flop. Outside EXTEST the pads carry the core's output data and enables. A chip-wide output-disable request turns every pad driver off, except while EXTEST is the current instruction. There is no test reset pin: holding mode select high walks the controller back to its reset state. The separate `rst_ni` is the device power-up reset and is not part of the test link.

Top module: `bscan_tap`

## Requirements
- R1: With tms_i held high, the controller reaches Test-Logic-Reset after at most five rising edges of tck_i. While in that state it loads BYPASS (3'b111) into the instruction register.
- R2: The controller follows the standard sixteen-state transitions on rising tck_i, including Pause-DR and Exit2-DR. A shift scan may be suspended in Pause-DR and resumed through Exit2-DR.
- R3: The instruction codes are EXTEST=3'b000, SAMPLE/PRELOAD=3'b001 and BYPASS=3'b111. Every other code behaves as BYPASS.
- R4: Capture-IR loads 3'b001 into the instruction shift stage. Both instruction and data shift stages shift toward bit 0, so bit 0 leaves on tdo first and tdi enters at the top bit. An instruction takes effect in Update-IR.
- R5: Under BYPASS the data path is one flop that captures 0 in Capture-DR. Data on tdo is tdi delayed by one shift.
- R6: Under SAMPLE/PRELOAD, Capture-DR copies pad_in_i (cell i = pad i) into the boundary shift stage, and Update-DR copies the shift stage into the hold stage. The pads stay on core_out_i and core_oe_i throughout.
- R7: Under EXTEST, Capture-DR also copies pad_in_i. pad_out_o equals the hold stage and pad_oe_o is all ones. The hold stage changes only in Update-DR.
- R8: When hiz_req_i is high and the instruction is not EXTEST, pad_oe_o is all zeros.
- R9: tdo_o changes only on falling tck_i. tdo_en_o is high only while the controller is in Shift-IR or Shift-DR.
- R10: While rst_ni is low, the controller is in Test-Logic-Reset with BYPASS, the hold stage is zero and tdo_en_o is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck_i | input | 1 | Test clock |
| rst_ni | input | 1 | Active-low asynchronous power-up reset |
| tms_i | input | 1 | Test mode select, sampled on rising tck_i |
| tdi_i | input | 1 | Serial test data in |
| tdo_o | output | 1 | Serial test data out, updated on falling tck_i |
| tdo_en_o | output | 1 | Drive enable for tdo_o (high in shift states) |
| hiz_req_i | input | 1 | Chip-wide request to disable all pad drivers |
| core_out_i | input | NUM_PADS | Output data from the core |
| core_oe_i | input | NUM_PADS | Output enables from the core |
| pad_in_i | input | NUM_PADS | Values seen at the pads |
| pad_out_o | output | NUM_PADS | Output data to the pad drivers |
| pad_oe_o | output | NUM_PADS | Output enables to the pad drivers |

## Verification
The properties assume that tms_i and tdi_i are steady around each rising tck_i. They also assume rst_ni is pulsed once at power-up, and that the core and pad inputs change only between edges. The bench drives every input just after the falling edge and reads outputs a nanosecond before the next rising edge. A behavioural model runs in step with the design and is compared each cycle. Scans pass through capture, shift, pause, resume and update with the disable request both high and low, so the EXTEST override and the ordinary forcing path are both exercised.

// File: rtl/bscan_pkg.sv
`timescale 1ns/1ps
package bscan_pkg;
  typedef enum logic [3:0] {
    ST_RESET, ST_IDLE,
    ST_SEL_DR, ST_CAP_DR, ST_SHIFT_DR, ST_EXIT1_DR, ST_PAUSE_DR, ST_EXIT2_DR, ST_UPD_DR,
    ST_SEL_IR, ST_CAP_IR, ST_SHIFT_IR, ST_EXIT1_IR, ST_PAUSE_IR, ST_EXIT2_IR, ST_UPD_IR
  } tap_state_e;

  localparam int IR_W = 3;
  localparam logic [IR_W-1:0] OP_EXTEST  = 3'b000;
  localparam logic [IR_W-1:0] OP_SAMPLE  = 3'b001;
  localparam logic [IR_W-1:0] OP_BYPASS  = 3'b111;
  localparam logic [IR_W-1:0] IR_CAPTURE = 3'b001;
endpackage

// File: rtl/tap_fsm.sv
`timescale 1ns/1ps
module tap_fsm
  import bscan_pkg::*;
(
  input  logic       tck_i,
  input  logic       rst_ni,
  input  logic       tms_i,
  output tap_state_e state_o
);
  tap_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_RESET:    state_d = tms_i ? ST_RESET    : ST_IDLE;
      ST_IDLE:     state_d = tms_i ? ST_SEL_DR   : ST_IDLE;
      ST_SEL_DR:   state_d = tms_i ? ST_SEL_IR   : ST_CAP_DR;
      ST_CAP_DR:   state_d = tms_i ? ST_EXIT1_DR : ST_SHIFT_DR;
      ST_SHIFT_DR: state_d = tms_i ? ST_EXIT1_DR : ST_SHIFT_DR;
      ST_EXIT1_DR: state_d = tms_i ? ST_UPD_DR   : ST_PAUSE_DR;
      ST_PAUSE_DR: state_d = tms_i ? ST_EXIT2_DR : ST_PAUSE_DR;
      ST_EXIT2_DR: state_d = tms_i ? ST_UPD_DR   : ST_SHIFT_DR;
      ST_UPD_DR:   state_d = tms_i ? ST_SEL_DR   : ST_IDLE;
      ST_SEL_IR:   state_d = tms_i ? ST_RESET    : ST_CAP_IR;
      ST_CAP_IR:   state_d = tms_i ? ST_EXIT1_IR : ST_SHIFT_IR;
      ST_SHIFT_IR: state_d = tms_i ? ST_EXIT1_IR : ST_SHIFT_IR;
      ST_EXIT1_IR: state_d = tms_i ? ST_UPD_IR   : ST_PAUSE_IR;
      ST_PAUSE_IR: state_d = tms_i ? ST_EXIT2_IR : ST_PAUSE_IR;
      ST_EXIT2_IR: state_d = tms_i ? ST_UPD_IR   : ST_SHIFT_IR;
      ST_UPD_IR:   state_d = tms_i ? ST_SEL_DR   : ST_IDLE;
      default:     state_d = ST_RESET;
    endcase
  end

  always_ff @(posedge tck_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_RESET;
    else         state_q <= state_d;
  end

  assign state_o = state_q;
endmodule

// File: rtl/instr_reg.sv
`timescale 1ns/1ps
module instr_reg
  import bscan_pkg::*;
(
  input  logic            tck_i,
  input  logic            rst_ni,
  input  tap_state_e      state_i,
  input  logic            tdi_i,
  output logic [IR_W-1:0] ir_o,
  output logic            so_o
);
  logic [IR_W-1:0] sh_q, ir_q;

  always_ff @(posedge tck_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q <= '0;
      ir_q <= OP_BYPASS;
    end else begin
      unique case (state_i)
        ST_CAP_IR:   sh_q <= IR_CAPTURE;
        ST_SHIFT_IR: sh_q <= {tdi_i, sh_q[IR_W-1:1]};
        ST_UPD_IR:   ir_q <= sh_q;
        ST_RESET:    ir_q <= OP_BYPASS;
        default: ;
      endcase
    end
  end

  assign ir_o = ir_q;
  assign so_o = sh_q[0];
endmodule

// File: rtl/boundary_reg.sv
`timescale 1ns/1ps
module boundary_reg #(
  parameter int NUM_PADS = 8
) (
  input  logic                tck_i,
  input  logic                rst_ni,
  input  logic                capture_i,
  input  logic                shift_i,
  input  logic                update_i,
  input  logic                tdi_i,
  input  logic [NUM_PADS-1:0] pad_in_i,
  output logic [NUM_PADS-1:0] hold_o,
  output logic                so_o
);
  logic [NUM_PADS-1:0] sh_q, hold_q;

  // cell i: shift input from cell i+1, top cell from tdi
  for (genvar i = 0; i < NUM_PADS; i++) begin : g_cell
    logic sin;
    if (i == NUM_PADS-1) begin : g_top
      assign sin = tdi_i;
    end else begin : g_mid
      assign sin = sh_q[i+1];
    end

    always_ff @(posedge tck_i or negedge rst_ni) begin
      if (!rst_ni) begin
        sh_q[i]   <= 1'b0;
        hold_q[i] <= 1'b0;
      end else begin
        if (capture_i)    sh_q[i]   <= pad_in_i[i];
        else if (shift_i) sh_q[i]   <= sin;
        if (update_i)     hold_q[i] <= sh_q[i];
      end
    end
  end

  assign hold_o = hold_q;
  assign so_o   = sh_q[0];
endmodule

// File: rtl/bscan_tap.sv
`timescale 1ns/1ps
module bscan_tap
  import bscan_pkg::*;
#(
  parameter int NUM_PADS = 8
) (
  input  logic                tck_i,
  input  logic                rst_ni,
  input  logic                tms_i,
  input  logic                tdi_i,
  output logic                tdo_o,
  output logic                tdo_en_o,
  input  logic                hiz_req_i,
  input  logic [NUM_PADS-1:0] core_out_i,
  input  logic [NUM_PADS-1:0] core_oe_i,
  input  logic [NUM_PADS-1:0] pad_in_i,
  output logic [NUM_PADS-1:0] pad_out_o,
  output logic [NUM_PADS-1:0] pad_oe_o
);
  tap_state_e          tap_state;
  logic [IR_W-1:0]     ir_q;
  logic                ir_so, bnd_so, byp_q;
  logic                is_extest, bnd_sel;
  logic [NUM_PADS-1:0] bnd_hold;
  logic                tdo_q, tdo_en_q;

  tap_fsm u_fsm (
    .tck_i  (tck_i),
    .rst_ni (rst_ni),
    .tms_i  (tms_i),
    .state_o(tap_state)
  );

  instr_reg u_ir (
    .tck_i  (tck_i),
    .rst_ni (rst_ni),
    .state_i(tap_state),
    .tdi_i  (tdi_i),
    .ir_o   (ir_q),
    .so_o   (ir_so)
  );

  assign is_extest = (ir_q == OP_EXTEST);
  assign bnd_sel   = is_extest || (ir_q == OP_SAMPLE);

  boundary_reg #(.NUM_PADS(NUM_PADS)) u_bnd (
    .tck_i    (tck_i),
    .rst_ni   (rst_ni),
    .capture_i(bnd_sel && tap_state == ST_CAP_DR),
    .shift_i  (bnd_sel && tap_state == ST_SHIFT_DR),
    .update_i (bnd_sel && tap_state == ST_UPD_DR),
    .tdi_i    (tdi_i),
    .pad_in_i (pad_in_i),
    .hold_o   (bnd_hold),
    .so_o     (bnd_so)
  );

  // unknown codes fall through to the bypass flop
  always_ff @(posedge tck_i or negedge rst_ni) begin
    if (!rst_ni)                                  byp_q <= 1'b0;
    else if (!bnd_sel && tap_state == ST_CAP_DR)   byp_q <= 1'b0;
    else if (!bnd_sel && tap_state == ST_SHIFT_DR) byp_q <= tdi_i;
  end

  always_ff @(negedge tck_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tdo_q    <= 1'b0;
      tdo_en_q <= 1'b0;
    end else begin
      tdo_en_q <= (tap_state == ST_SHIFT_IR) || (tap_state == ST_SHIFT_DR);
      if (tap_state == ST_SHIFT_IR) tdo_q <= ir_so;
      else                          tdo_q <= bnd_sel ? bnd_so : byp_q;
    end
  end

  assign tdo_o     = tdo_q;
  assign tdo_en_o  = tdo_en_q;
  assign pad_out_o = is_extest ? bnd_hold : core_out_i;
  assign pad_oe_o  = is_extest ? '1 : (hiz_req_i ? '0 : core_oe_i);
endmodule

// File: rtl/bscan_tap_chk.sv
`timescale 1ns/1ps
module bscan_tap_chk
  import bscan_pkg::*;
#(
  parameter int NUM_PADS = 8
) (
  input logic                tck_i,
  input logic                rst_ni,
  input logic                tms_i,
  input logic                hiz_req_i,
  input tap_state_e          state_i,
  input logic [IR_W-1:0]     ir_i,
  input logic [NUM_PADS-1:0] hold_i,
  input logic [NUM_PADS-1:0] pad_out_o,
  input logic [NUM_PADS-1:0] pad_oe_o,
  input logic                tdo_en_o
);
  logic [2:0] ones_q;

  always_ff @(posedge tck_i or negedge rst_ni) begin
    if (!rst_ni)          ones_q <= '0;
    else if (!tms_i)      ones_q <= '0;
    else if (ones_q != 7) ones_q <= ones_q + 3'd1;
  end

  a_r1_five_high: assert property (@(posedge tck_i) disable iff (!rst_ni)
    (tms_i && ones_q >= 3'd4) |=> state_i == ST_RESET);

  a_r1_reset_bypass: assert property (@(posedge tck_i) disable iff (!rst_ni)
    (state_i == ST_RESET) |=> ir_i == OP_BYPASS);

  a_r8_hiz_forced: assert property (@(posedge tck_i) disable iff (!rst_ni)
    (hiz_req_i && ir_i != OP_EXTEST) |-> pad_oe_o == '0);

  a_r7_extest_drive: assert property (@(posedge tck_i) disable iff (!rst_ni)
    (ir_i == OP_EXTEST) |-> (pad_oe_o == '1 && pad_out_o == hold_i));

  a_r7_hold_stable: assert property (@(posedge tck_i) disable iff (!rst_ni)
    (state_i != ST_UPD_DR) |=> $stable(hold_i));

  a_r9_tdo_window: assert property (@(posedge tck_i) disable iff (!rst_ni)
    tdo_en_o == (state_i == ST_SHIFT_IR || state_i == ST_SHIFT_DR));
endmodule

bind bscan_tap bscan_tap_chk #(.NUM_PADS(NUM_PADS)) u_chk (
  .tck_i    (tck_i),
  .rst_ni   (rst_ni),
  .tms_i    (tms_i),
  .hiz_req_i(hiz_req_i),
  .state_i  (tap_state),
  .ir_i     (ir_q),
  .hold_i   (bnd_hold),
  .pad_out_o(pad_out_o),
  .pad_oe_o (pad_oe_o),
  .tdo_en_o (tdo_en_o)
);

// File: tb/sim_bscan_tap.sv
`timescale 1ns/1ps
module sim_bscan_tap;
  localparam int N = 8;

  logic         tck = 1'b0, rst_n = 1'b0, tms = 1'b1, tdi = 1'b0, hiz = 1'b0;
  logic [N-1:0] core_out = 8'h5A, core_oe = 8'hF0, pad_in = 8'h00;
  logic         tdo, tdo_en;
  logic [N-1:0] pad_out, pad_oe;

  int errors = 0, checks = 0;
  bit done = 0;

  always #2.5 tck = ~tck;

  bscan_tap #(.NUM_PADS(N)) u0 (
    .tck_i(tck), .rst_ni(rst_n), .tms_i(tms), .tdi_i(tdi),
    .tdo_o(tdo), .tdo_en_o(tdo_en), .hiz_req_i(hiz),
    .core_out_i(core_out), .core_oe_i(core_oe), .pad_in_i(pad_in),
    .pad_out_o(pad_out), .pad_oe_o(pad_oe)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  localparam int TLR = 0, RTI = 1, SDR = 2, CDR = 3, HDR = 4, X1D = 5, PDR = 6, X2D = 7, UDR = 8,
                 SIR = 9, CIR = 10, HIR = 11, X1I = 12, PIR = 13, X2I = 14, UIR = 15;
  int           m_st = TLR;
  logic [2:0]   m_ir = 3'b111, m_irs = 3'b000;
  logic [N-1:0] m_bs = '0, m_bu = '0;
  logic         m_by = 1'b0, m_tdo = 1'b0, m_en = 1'b0;

  function automatic int nxt(input int s, input logic m);
    case (s)
      TLR: return m ? TLR : RTI;
      RTI: return m ? SDR : RTI;
      SDR: return m ? SIR : CDR;
      SIR: return m ? TLR : CIR;
      CDR, HDR: return m ? X1D : HDR;
      X1D: return m ? UDR : PDR;
      PDR: return m ? X2D : PDR;
      X2D: return m ? UDR : HDR;
      CIR, HIR: return m ? X1I : HIR;
      X1I: return m ? UIR : PIR;
      PIR: return m ? X2I : PIR;
      X2I: return m ? UIR : HIR;
      default: return m ? SDR : RTI;
    endcase
  endfunction

  function automatic bit m_bnd();
    return (m_ir == 3'b000) || (m_ir == 3'b001);
  endfunction

  always @(posedge tck) begin
    if (!rst_n) begin
      m_st = TLR; m_ir = 3'b111; m_irs = '0; m_bs = '0; m_bu = '0; m_by = 0;
    end else begin
      case (m_st)
        TLR: m_ir = 3'b111;
        CIR: m_irs = 3'b001;
        HIR: m_irs = {tdi, m_irs[2:1]};
        UIR: m_ir = m_irs;
        CDR: if (m_bnd()) m_bs = pad_in; else m_by = 1'b0;
        HDR: if (m_bnd()) m_bs = {tdi, m_bs[N-1:1]}; else m_by = tdi;
        UDR: if (m_bnd()) m_bu = m_bs;
        default: ;
      endcase
      m_st = nxt(m_st, tms);
    end
  end

  always @(negedge tck) begin
    if (!rst_n) begin
      m_en = 0; m_tdo = 0;
    end else begin
      m_en  = (m_st == HIR) || (m_st == HDR);
      m_tdo = (m_st == HIR) ? m_irs[0] : (m_bnd() ? m_bs[0] : m_by);
    end
    #1.5;
    if (rst_n) begin
      chk("R2 tdo_en per cycle", tdo_en, m_en);
      if (m_en) chk("R9 tdo per cycle", tdo, m_tdo);
      chk("R7 pad_out per cycle", pad_out, (m_ir == 3'b000) ? m_bu : core_out);
      chk("R8 pad_oe per cycle", pad_oe,
          (m_ir == 3'b000) ? {N{1'b1}} : (hiz ? {N{1'b0}} : core_oe));
    end
  end

  // ---------------- stimulus ----------------
  task automatic step(input logic m, input logic d);
    tms = m; tdi = d;
    @(posedge tck); @(negedge tck); #0.5;
  endtask

  task automatic scan_ir(input logic [2:0] v, output logic [2:0] cap);
    step(1, 0); step(1, 0); step(0, 0); step(0, 0);
    for (int i = 0; i < 3; i++) begin
      cap[i] = tdo;
      step(i == 2, v[i]);
    end
    step(1, 0); step(0, 0);
  endtask

  task automatic scan_dr(input logic [N-1:0] v, output logic [N-1:0] cap);
    step(1, 0); step(0, 0); step(0, 0);
    for (int i = 0; i < N; i++) begin
      cap[i] = tdo;
      step(i == N-1, v[i]);
    end
    step(1, 0); step(0, 0);
  endtask

  logic [2:0]   icap;
  logic [N-1:0] dcap;
  logic         held;

  initial begin
    @(negedge tck); @(negedge tck); #0.5;
    // R10: reset state, before release
    chk("R10 tdo_en in reset", tdo_en, 1'b0);
    chk("R10 pad_out in reset", pad_out, core_out);
    chk("R10 pad_oe in reset", pad_oe, core_oe);
    rst_n = 1'b1;
    step(0, 0);

    // R4: IR capture pattern; load SAMPLE/PRELOAD
    scan_ir(3'b001, icap);
    chk("R4 IR capture", icap, 3'b001);

    // R6: sample pads, preload hold stage, pads stay on core
    pad_in = 8'hA5;
    scan_dr(8'h3C, dcap);
    chk("R6 sampled pads", dcap, 8'hA5);
    chk("R6 pads follow core", pad_out, core_out);

    // R7: EXTEST drives preloaded hold stage, all enables on even with hiz
    hiz = 1'b1;
    scan_ir(3'b000, icap);
    chk("R7 extest preload drives pads", pad_out, 8'h3C);
    chk("R8 extest overrides hiz", pad_oe, 8'hFF);
    pad_in = 8'h0F;
    scan_dr(8'hC3, dcap);
    chk("R7 extest capture", dcap, 8'h0F);
    chk("R7 extest update", pad_out, 8'hC3);

    // R1: five TMS-high edges reach reset, instruction becomes BYPASS
    for (int i = 0; i < 5; i++) step(1, 0);
    chk("R8 hiz forces off after reset", pad_oe, 8'h00);
    chk("R1 pads back on core", pad_out, core_out);
    step(0, 0);
    scan_dr(8'h96, dcap);
    chk("R5 bypass one-bit delay", dcap, {8'h96 << 1});

    // R3: unknown code acts as bypass
    hiz = 1'b0;
    scan_ir(3'b010, icap);
    chk("R4 IR capture again", icap, 3'b001);
    scan_dr(8'h6D, dcap);
    chk("R3 unknown code is bypass", dcap, {8'h6D << 1});
    chk("R3 pads on core", pad_oe, core_oe);

    // R9 / R2: falling-edge TDO, pause and resume
    step(1, 0); step(0, 0); step(0, 0);   // Shift-DR, bypass holds 0
    chk("R9 tdo before shift", tdo, 1'b0);
    tms = 0; tdi = 1;
    @(posedge tck); #0.5;
    held = tdo;
    chk("R9 tdo stable at rising edge", held, 1'b0);
    @(negedge tck); #0.5;
    chk("R9 tdo at falling edge", tdo, 1'b1);
    step(1, 0); step(0, 0);               // Exit1-DR, Pause-DR
    chk("R2 no drive in pause", tdo_en, 1'b0);
    step(1, 0); step(0, 0);               // Exit2-DR, Shift-DR
    chk("R2 resumed shift", tdo_en, 1'b1);
    step(1, 0); step(1, 0); step(0, 0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #1000000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule